// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier with Result Classification

This block multiplies two IEEE-754 single-precision operands in one registered stage. The exponents are added, the 24-bit significands are multiplied, and the product is normalized. The product is then rounded under a 2-bit rounding-mode input. Subnormal operands are normalized on entry, so they take part in the product like any other value. Results too small for the normal range come out as subnormals or zero, with gradual underflow.

Each accepted operation returns the 32-bit product, four exception flags (invalid, overflow, underflow, inexact) and a 5-bit code that gives the class and sign of the result. A trap-enable input for invalid operations can block the write. When it is set and the operation is invalid, the block writes no product, and both the product and the class code keep their previous values. A record request asks for a 4-bit condition summary, meant for a condition-register field, alongside the result.

Top module: `fp_mul_unit`

## Requirements
- R1: An operation presented with `in_valid` high at a rising edge appears on the outputs after that edge, and `out_valid` is high for exactly that one following cycle. Synchronous reset clears `out_valid`, `res_wr`, `product`, `class_code`, all flags, `cr_valid` and `cr_sum` to zero.
- R2: For finite nonzero operands, the product is formed by exponent addition and significand multiplication, then normalized. An exact product raises no flag (1.5 x 2.0 = 0x40400000, 3.0 x 3.0 = 0x41100000).
- R3: `rnd_mode` selects the rounding: 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. A product that is not exact raises the inexact flag.
- R4: When the rounded exponent reaches 255, overflow and inexact are both set. The result is signed infinity under nearest, under +infinity for positive results and under -infinity for negative results. In every other case it is the largest finite value of that sign (0x7F7FFFFF).
- R5: Subnormal operands are normalized before the multiply. A result below 2^-126 is delivered as a subnormal or zero. Underflow is raised when the exact result is below 2^-126 and rounding lost bits.
- R6: Invalid is raised for infinity times zero, in either operand order, and for any signaling NaN operand. A signaling NaN has exponent 255, a nonzero fraction and fraction bit 22 clear. With `inv_en` low, the result is the default quiet NaN 0x7FC00000.
- R7: With `inv_en` high, an invalid operation drives `res_wr` low. `product` and `class_code` keep their previous values, and `flag_inv` is still reported.
- R8: With no invalid operation, a quiet NaN operand is returned unchanged. Operand A takes precedence when both are NaN.
- R9: The sign of a zero or infinity result is the XOR of the operand signs.
- R10: `class_code` reports the written result. Any NaN gives 10001, -inf 01001, -normal 01000, -subnormal 11000, -zero 10010, +zero 00010, +subnormal 10100, +normal 00100 and +inf 00101.
- R11: When `rec_req` is high, `cr_valid` is high with the result. `cr_sum` is then set as follows: bit 3 is the OR of the four flags, bit 2 is invalid AND `inv_en`, bit 1 is invalid and bit 0 is overflow. When `rec_req` is low, `cr_valid` and `cr_sum` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| rnd_mode | input | 2 | Rounding-mode select |
| inv_en | input | 1 | Invalid-operation trap enable |
| rec_req | input | 1 | Request the condition summary |
| out_valid | output | 1 | Result valid |
| res_wr | output | 1 | Result and class were written this operation |
| product | output | 32 | Product |
| class_code | output | 5 | Class and sign of the last written result |
| flag_inv | output | 1 | Invalid operation |
| flag_ovf | output | 1 | Overflow |
| flag_unf | output | 1 | Underflow |
| flag_inx | output | 1 | Inexact |
| cr_valid | output | 1 | Condition summary valid |
| cr_sum | output | 4 | Condition summary |

## Verification
Rounding is probed with products whose bits beyond the fraction are an exact tie with an odd last bit, an exact tie with an even last bit, and a sticky-only remainder. A design that ignored the tie-to-even rule or the direction of a mode would be off by one unit in the last place. Overflow is checked in all four modes and with both signs, to catch a block that always saturates or always returns infinity. Underflow cases cover an exact subnormal result (no flag), a halfway subnormal, and a total underflow that becomes zero or the smallest subnormal depending on the mode. A subnormal operand whose product lands exactly on 2^-126 exposes any failure to normalize the inputs. The trapped-invalid case follows a normal result, so a design that overwrote the product or the class code would show the wrong value.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int EXT_W   = EXP_W + 2;
    localparam int LZ_W    = $clog2(SIG_W + 1);
    localparam int CLS_W   = 5;

    localparam logic [WORD_W-1:0] QNAN_DEFAULT = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_UP      = 2'b10,
        RM_DOWN    = 2'b11
    } rmode_e;

    typedef struct packed {
        logic                     sign;
        logic                     is_zero;
        logic                     is_inf;
        logic                     is_nan;
        logic                     is_snan;
        logic signed [EXT_W-1:0]  exp;
        logic [SIG_W-1:0]         sig;
    } opnd_t;

    typedef struct packed {
        logic inv;
        logic ovf;
        logic unf;
        logic inx;
    } flags_t;

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [SIG_W-1:0] s);
        logic [LZ_W-1:0] n;
        n = LZ_W'(SIG_W);
        for (int i = 0; i < SIG_W; i++) begin
            if (s[i]) n = LZ_W'(SIG_W - 1 - i);
        end
        return n;
    endfunction

    function automatic logic [CLS_W-1:0] class_of(input logic [WORD_W-1:0] w);
        logic              s;
        logic [EXP_W-1:0]  e;
        logic [FRAC_W-1:0] f;
        s = w[WORD_W-1];
        e = w[WORD_W-2 -: EXP_W];
        f = w[FRAC_W-1:0];
        if (e == EXP_W'(EXP_MAX))
            return (f != '0) ? 5'b10001 : (s ? 5'b01001 : 5'b00101);
        else if (e == '0)
            return (f == '0) ? (s ? 5'b10010 : 5'b00010) : (s ? 5'b11000 : 5'b10100);
        else
            return s ? 5'b01000 : 5'b00100;
    endfunction
endpackage

// File: rtl/fpm_unpack.sv
`timescale 1ns/1ps
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output opnd_t             opnd
);
    logic [EXP_W-1:0]  raw_e;
    logic [FRAC_W-1:0] raw_f;
    logic [SIG_W-1:0]  raw_sig;
    logic [EXT_W-1:0]  raw_exp;
    logic [LZ_W-1:0]   lz;

    always_comb begin
        raw_e   = word[WORD_W-2 -: EXP_W];
        raw_f   = word[FRAC_W-1:0];
        raw_sig = {raw_e != '0, raw_f};
        raw_exp = (raw_e == '0) ? EXT_W'(1) : EXT_W'(raw_e);
        lz      = lead_zeros(raw_sig);

        opnd.sign    = word[WORD_W-1];
        opnd.is_zero = (raw_e == '0) && (raw_f == '0);
        opnd.is_inf  = (raw_e == EXP_W'(EXP_MAX)) && (raw_f == '0);
        opnd.is_nan  = (raw_e == EXP_W'(EXP_MAX)) && (raw_f != '0);
        opnd.is_snan = opnd.is_nan && !raw_f[FRAC_W-1];
        // subnormals are shifted up so the leading one sits at the top
        opnd.sig     = raw_sig << lz;
        opnd.exp     = raw_exp - EXT_W'(lz);
    end
endmodule

// File: rtl/fpm_sigmul.sv
`timescale 1ns/1ps
module fpm_sigmul
    import fpm_pkg::*;
(
    input  opnd_t                   a,
    input  opnd_t                   b,
    output logic signed [EXT_W-1:0] exp_n,
    output logic [PROD_W-1:0]       sig_n
);
    localparam logic signed [EXT_W-1:0] BIAS_X = EXT_W'(BIAS);
    localparam logic signed [EXT_W-1:0] ONE_X  = EXT_W'(1);

    logic [PROD_W-1:0]       raw_p;
    logic signed [EXT_W-1:0] esum;

    always_comb begin
        raw_p = PROD_W'(a.sig) * PROD_W'(b.sig);
        esum  = a.exp + b.exp - BIAS_X;
        // normalized inputs leave the leading one in one of the two top bits
        if (raw_p[PROD_W-1]) begin
            exp_n = esum + ONE_X;
            sig_n = raw_p;
        end else begin
            exp_n = esum;
            sig_n = raw_p << 1;
        end
    end
endmodule

// File: rtl/fpm_round.sv
`timescale 1ns/1ps
module fpm_round
    import fpm_pkg::*;
(
    input  logic                    sign,
    input  logic signed [EXT_W-1:0] exp_n,
    input  logic [PROD_W-1:0]       sig_n,
    input  rmode_e                  rmode,
    output logic [WORD_W-1:0]       word,
    output logic                    ovf,
    output logic                    unf,
    output logic                    inx
);
    localparam int SH_CAP  = SIG_W + 2;
    localparam int SH_W    = $clog2(SH_CAP + 1);
    localparam int WIDE_W  = PROD_W + SH_CAP;
    localparam int PK_W    = EXT_W + FRAC_W;
    localparam logic signed [EXT_W-1:0] ONE_X = EXT_W'(1);
    localparam logic signed [EXT_W-1:0] CAP_X = EXT_W'(SH_CAP);

    logic                    tiny;
    logic signed [EXT_W-1:0] need;
    logic [SH_W-1:0]         sh;
    logic [WIDE_W-1:0]       wide;
    logic [SIG_W-1:0]        mant;
    logic                    guard, sticky, lost, inc, to_inf;
    logic [EXT_W-1:0]        exp_field, rexp;
    logic [PK_W-1:0]         pk;

    always_comb begin
        tiny = exp_n < ONE_X;
        need = ONE_X - exp_n;
        if (!tiny)
            sh = '0;
        else if (need > CAP_X)
            sh = SH_W'(SH_CAP);
        else
            sh = need[SH_W-1:0];

        wide   = {sig_n, {SH_CAP{1'b0}}} >> sh;
        mant   = wide[WIDE_W-1 -: SIG_W];
        guard  = wide[WIDE_W-1-SIG_W];
        sticky = |wide[WIDE_W-2-SIG_W:0];
        lost   = guard | sticky;

        unique case (rmode)
            RM_NEAREST: inc = guard & (sticky | mant[0]);
            RM_ZERO:    inc = 1'b0;
            RM_UP:      inc = lost & !sign;
            RM_DOWN:    inc = lost & sign;
            default:    inc = 1'b0;
        endcase

        // carry out of the fraction moves into the exponent field
        exp_field = tiny ? '0 : exp_n;
        pk        = {exp_field, mant[FRAC_W-1:0]} + PK_W'(inc);
        rexp      = pk[PK_W-1:FRAC_W];

        ovf    = !tiny && (rexp >= EXT_W'(EXP_MAX));
        to_inf = (rmode == RM_NEAREST) || (rmode == RM_UP && !sign) || (rmode == RM_DOWN && sign);
        if (ovf)
            word = to_inf ? {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                          : {sign, EXP_W'(EXP_MAX - 1), {FRAC_W{1'b1}}};
        else
            word = {sign, rexp[EXP_W-1:0], pk[FRAC_W-1:0]};

        unf = tiny & lost;
        inx = lost | ovf;
    end
endmodule

// File: rtl/fp_mul_unit.sv
`timescale 1ns/1ps
module fp_mul_unit
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       op_a,
    input  logic [31:0]       op_b,
    input  logic [1:0]        rnd_mode,
    input  logic              inv_en,
    input  logic              rec_req,
    output logic              out_valid,
    output logic              res_wr,
    output logic [31:0]       product,
    output logic [4:0]        class_code,
    output logic              flag_inv,
    output logic              flag_ovf,
    output logic              flag_unf,
    output logic              flag_inx,
    output logic              cr_valid,
    output logic [3:0]        cr_sum
);
    localparam int N_OPS = 2;

    logic [WORD_W-1:0] words [N_OPS];
    opnd_t             opn   [N_OPS];

    assign words[0] = op_a;
    assign words[1] = op_b;

    for (genvar g = 0; g < N_OPS; g++) begin : g_unpack
        fpm_unpack u_unpack (.word(words[g]), .opnd(opn[g]));
    end

    logic signed [EXT_W-1:0] exp_n;
    logic [PROD_W-1:0]       sig_n;
    logic [WORD_W-1:0]       core_word;
    logic                    core_ovf, core_unf, core_inx;
    logic                    rsign;

    assign rsign = opn[0].sign ^ opn[1].sign;

    fpm_sigmul u_sigmul (.a(opn[0]), .b(opn[1]), .exp_n(exp_n), .sig_n(sig_n));

    fpm_round u_round (
        .sign(rsign), .exp_n(exp_n), .sig_n(sig_n), .rmode(rmode_e'(rnd_mode)),
        .word(core_word), .ovf(core_ovf), .unf(core_unf), .inx(core_inx)
    );

    logic [WORD_W-1:0] nxt_word;
    flags_t            nxt_flags;
    logic              nxt_wr;

    always_comb begin
        nxt_flags     = '0;
        nxt_flags.inv = opn[0].is_snan | opn[1].is_snan
                      | (opn[0].is_inf & opn[1].is_zero)
                      | (opn[0].is_zero & opn[1].is_inf);
        if (nxt_flags.inv)
            nxt_word = QNAN_DEFAULT;
        else if (opn[0].is_nan)
            nxt_word = op_a;
        else if (opn[1].is_nan)
            nxt_word = op_b;
        else if (opn[0].is_inf | opn[1].is_inf)
            nxt_word = {rsign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (opn[0].is_zero | opn[1].is_zero)
            nxt_word = {rsign, {(WORD_W-1){1'b0}}};
        else begin
            nxt_word      = core_word;
            nxt_flags.ovf = core_ovf;
            nxt_flags.unf = core_unf;
            nxt_flags.inx = core_inx;
        end
        nxt_wr = !(nxt_flags.inv & inv_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            res_wr     <= 1'b0;
            product    <= '0;
            class_code <= '0;
            flag_inv   <= 1'b0;
            flag_ovf   <= 1'b0;
            flag_unf   <= 1'b0;
            flag_inx   <= 1'b0;
            cr_valid   <= 1'b0;
            cr_sum     <= '0;
        end else begin
            out_valid <= in_valid;
            res_wr    <= in_valid & nxt_wr;
            cr_valid  <= in_valid & rec_req;
            if (in_valid) begin
                flag_inv <= nxt_flags.inv;
                flag_ovf <= nxt_flags.ovf;
                flag_unf <= nxt_flags.unf;
                flag_inx <= nxt_flags.inx;
                if (nxt_wr) begin
                    product    <= nxt_word;
                    class_code <= class_of(nxt_word);
                end
                cr_sum <= rec_req ? {|nxt_flags, nxt_flags.inv & inv_en, nxt_flags.inv, nxt_flags.ovf}
                                  : 4'b0000;
            end else begin
                cr_sum <= 4'b0000;
            end
        end
    end

    p_valid_next_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid)
        else $error("R1: out_valid missing after request");

    p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !res_wr && !cr_valid)
        else $error("R1: output strobe without request");

    p_ovf_inexact_r4: assert property (@(posedge clk) disable iff (rst)
        flag_ovf |-> flag_inx)
        else $error("R4: overflow without inexact");

    p_unf_inexact_r5: assert property (@(posedge clk) disable iff (rst)
        flag_unf |-> flag_inx)
        else $error("R5: underflow without inexact");

    p_default_nan_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && res_wr && flag_inv) |-> (product == QNAN_DEFAULT) && (class_code == 5'b10001))
        else $error("R6: invalid result is not the default quiet NaN");

    p_hold_on_trap_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !res_wr) |-> $stable(product) && $stable(class_code))
        else $error("R7: product or class changed without a write");

    p_trap_needs_inv_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !res_wr) |-> flag_inv)
        else $error("R7: write suppressed without invalid");

    p_cr_fields_r11: assert property (@(posedge clk) disable iff (rst)
        cr_valid |-> out_valid && (cr_sum[1] == flag_inv) && (cr_sum[0] == flag_ovf)
                     && (cr_sum[3] == (flag_inv | flag_ovf | flag_unf | flag_inx)))
        else $error("R11: condition summary disagrees with flags");
endmodule

// File: tb/fp_mul_unit_tb.sv
`timescale 1ns/1ps
module fp_mul_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  rnd_mode = '0;
    logic        inv_en = 1'b0;
    logic        rec_req = 1'b0;
    logic        out_valid, res_wr, flag_inv, flag_ovf, flag_unf, flag_inx, cr_valid;
    logic [31:0] product;
    logic [4:0]  class_code;
    logic [3:0]  cr_sum;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fp_mul_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .rnd_mode(rnd_mode), .inv_en(inv_en), .rec_req(rec_req),
        .out_valid(out_valid), .res_wr(res_wr), .product(product), .class_code(class_code),
        .flag_inv(flag_inv), .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_inx(flag_inx),
        .cr_valid(cr_valid), .cr_sum(cr_sum)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm,
                          input logic ie, input logic rec);
        @(negedge clk);
        op_a = a; op_b = b; rnd_mode = rm; inv_en = ie; rec_req = rec; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rec_req = 1'b0;
    endtask

    // flags packed as {inv, ovf, unf, inx}
    task automatic expect_res(input string tag, input logic [31:0] p, input logic [4:0] cls,
                              input logic [3:0] fl);
        chk({tag, " out_valid"}, 32'(out_valid), 32'd1);
        chk({tag, " product"}, product, p);
        chk({tag, " class"}, 32'(class_code), 32'(cls));
        chk({tag, " flags"}, 32'({flag_inv, flag_ovf, flag_unf, flag_inx}), 32'(fl));
    endtask

    task automatic t_reset;
        chk("R1 reset out_valid", 32'(out_valid), 32'd0);
        chk("R1 reset product", product, 32'h0);
        chk("R1 reset class", 32'(class_code), 32'h0);
        chk("R1 reset flags", 32'({flag_inv, flag_ovf, flag_unf, flag_inx}), 32'h0);
        chk("R1 reset cr", 32'({cr_valid, res_wr, cr_sum}), 32'h0);
    endtask

    task automatic t_basic;
        run_op(32'h3FC00000, 32'h40000000, 2'b00, 1'b0, 1'b0);
        expect_res("R2 1.5x2", 32'h40400000, 5'b00100, 4'b0000);
        chk("R1 res_wr", 32'(res_wr), 32'd1);
        run_op(32'h40400000, 32'h40400000, 2'b00, 1'b0, 1'b0);
        expect_res("R2 3x3", 32'h41100000, 5'b00100, 4'b0000);
        run_op(32'hBFC00000, 32'h40000000, 2'b00, 1'b0, 1'b0);
        expect_res("R10 negative normal", 32'hC0400000, 5'b01000, 4'b0000);
        @(negedge clk);
        chk("R1 single-cycle valid", 32'(out_valid), 32'd0);
        chk("R11 no record", 32'({cr_valid, cr_sum}), 32'h0);
    endtask

    task automatic t_round;
        run_op(32'h3F800001, 32'h3F800001, 2'b00, 1'b0, 1'b0);
        expect_res("R3 sticky nearest", 32'h3F800002, 5'b00100, 4'b0001);
        run_op(32'h3F800001, 32'h3F800001, 2'b10, 1'b0, 1'b0);
        expect_res("R3 sticky up", 32'h3F800003, 5'b00100, 4'b0001);
        run_op(32'h3F800001, 32'h3F800001, 2'b11, 1'b0, 1'b0);
        expect_res("R3 sticky down pos", 32'h3F800002, 5'b00100, 4'b0001);
        run_op(32'hBF800001, 32'h3F800001, 2'b11, 1'b0, 1'b0);
        expect_res("R3 sticky down neg", 32'hBF800003, 5'b01000, 4'b0001);
        run_op(32'hBF800001, 32'h3F800001, 2'b10, 1'b0, 1'b0);
        expect_res("R3 sticky up neg", 32'hBF800002, 5'b01000, 4'b0001);
        run_op(32'h3F800001, 32'h3FC00000, 2'b00, 1'b0, 1'b0);
        expect_res("R3 tie odd", 32'h3FC00002, 5'b00100, 4'b0001);
        run_op(32'h3F800001, 32'h3FC00000, 2'b01, 1'b0, 1'b0);
        expect_res("R3 tie toward zero", 32'h3FC00001, 5'b00100, 4'b0001);
        run_op(32'h3F800003, 32'h3FC00000, 2'b00, 1'b0, 1'b0);
        expect_res("R3 tie even", 32'h3FC00004, 5'b00100, 4'b0001);
    endtask

    task automatic t_overflow;
        run_op(32'h7F000000, 32'h40000000, 2'b00, 1'b0, 1'b1);
        expect_res("R4 nearest", 32'h7F800000, 5'b00101, 4'b0101);
        chk("R11 cr_valid", 32'(cr_valid), 32'd1);
        chk("R11 cr overflow", 32'(cr_sum), 32'b1001);
        run_op(32'h7F000000, 32'h40000000, 2'b01, 1'b0, 1'b0);
        expect_res("R4 toward zero", 32'h7F7FFFFF, 5'b00100, 4'b0101);
        run_op(32'h7F000000, 32'h40000000, 2'b11, 1'b0, 1'b0);
        expect_res("R4 down pos", 32'h7F7FFFFF, 5'b00100, 4'b0101);
        run_op(32'hFF000000, 32'h40000000, 2'b10, 1'b0, 1'b0);
        expect_res("R4 up neg", 32'hFF7FFFFF, 5'b01000, 4'b0101);
        run_op(32'hFF000000, 32'h40000000, 2'b11, 1'b0, 1'b0);
        expect_res("R4 down neg", 32'hFF800000, 5'b01001, 4'b0101);
    endtask

    task automatic t_underflow;
        run_op(32'h00800000, 32'h3F000000, 2'b00, 1'b0, 1'b0);
        expect_res("R5 exact subnormal", 32'h00400000, 5'b10100, 4'b0000);
        run_op(32'h80800000, 32'h3F000000, 2'b00, 1'b0, 1'b0);
        expect_res("R10 negative subnormal", 32'h80400000, 5'b11000, 4'b0000);
        run_op(32'h00800001, 32'h3F000000, 2'b00, 1'b0, 1'b0);
        expect_res("R5 halfway nearest", 32'h00400000, 5'b10100, 4'b0011);
        run_op(32'h00800001, 32'h3F000000, 2'b10, 1'b0, 1'b0);
        expect_res("R5 halfway up", 32'h00400001, 5'b10100, 4'b0011);
        run_op(32'h00800000, 32'h00800000, 2'b00, 1'b0, 1'b0);
        expect_res("R5 flush nearest", 32'h00000000, 5'b00010, 4'b0011);
        run_op(32'h00800000, 32'h00800000, 2'b10, 1'b0, 1'b0);
        expect_res("R5 flush up", 32'h00000001, 5'b10100, 4'b0011);
        run_op(32'h00000001, 32'h4B000000, 2'b00, 1'b0, 1'b0);
        expect_res("R5 subnormal operand", 32'h00800000, 5'b00100, 4'b0000);
    endtask

    task automatic t_invalid;
        run_op(32'h7F800000, 32'h00000000, 2'b00, 1'b0, 1'b1);
        expect_res("R6 inf x zero", 32'h7FC00000, 5'b10001, 4'b1000);
        chk("R11 cr invalid untrapped", 32'(cr_sum), 32'b1010);
        run_op(32'h3F800000, 32'h7F800001, 2'b00, 1'b0, 1'b0);
        expect_res("R6 signaling nan", 32'h7FC00000, 5'b10001, 4'b1000);
        run_op(32'h3FC00000, 32'h40000000, 2'b00, 1'b1, 1'b0);
        expect_res("R7 setup", 32'h40400000, 5'b00100, 4'b0000);
        run_op(32'h80000000, 32'h7F800000, 2'b00, 1'b1, 1'b1);
        expect_res("R7 trapped hold", 32'h40400000, 5'b00100, 4'b1000);
        chk("R7 res_wr low", 32'(res_wr), 32'd0);
        chk("R11 cr invalid trapped", 32'(cr_sum), 32'b1110);
    endtask

    task automatic t_nan;
        run_op(32'h3F800000, 32'hFFC00123, 2'b00, 1'b0, 1'b0);
        expect_res("R8 nan in b", 32'hFFC00123, 5'b10001, 4'b0000);
        run_op(32'h7FC00005, 32'hFFC00123, 2'b00, 1'b0, 1'b0);
        expect_res("R8 a wins", 32'h7FC00005, 5'b10001, 4'b0000);
        run_op(32'h7FC00005, 32'h7F800000, 2'b00, 1'b1, 1'b0);
        expect_res("R8 quiet nan x inf", 32'h7FC00005, 5'b10001, 4'b0000);
    endtask

    task automatic t_sign;
        run_op(32'h80000000, 32'h3F800000, 2'b00, 1'b0, 1'b0);
        expect_res("R9 neg zero", 32'h80000000, 5'b10010, 4'b0000);
        run_op(32'h00000000, 32'hBF800000, 2'b00, 1'b0, 1'b0);
        expect_res("R9 zero x neg", 32'h80000000, 5'b10010, 4'b0000);
        run_op(32'hFF800000, 32'h3F800000, 2'b00, 1'b0, 1'b0);
        expect_res("R9 neg inf", 32'hFF800000, 5'b01001, 4'b0000);
        run_op(32'hFF800000, 32'hC0000000, 2'b00, 1'b0, 1'b0);
        expect_res("R9 inf neg x neg", 32'h7F800000, 5'b00101, 4'b0000);
        run_op(32'h80000000, 32'h80000000, 2'b00, 1'b0, 1'b0);
        expect_res("R10 positive zero", 32'h00000000, 5'b00010, 4'b0000);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_basic;
        t_round;
        t_overflow;
        t_underflow;
        t_invalid;
        t_nan;
        t_sign;
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule